// File: doc/BRIEF.md
# Tape Reader Strobe Controller

This block links a high-speed punched-tape reader to a strobed parallel input port. The reader reports the sprocket hole, which is present at every character position. The block turns the rising edge of that signal into an active-low load strobe for the port's input latch. It then watches the port's buffer-full flag. When the flag rises, the block ends the strobe. The same flag decides whether the reader motor runs, coasts or brakes.

While the host has not yet read the character and the sprocket hole is still visible, the motor coasts. If the hole passes while the character is still unread, the brake is applied, so the tape stops before the next character. The motor runs again once the host read clears the flag. A strobe that the flag never acknowledges would lose data. The block detects this with a programmable timeout and raises a latched alarm.

Both inputs pass through two synchronising flops. All logic runs in a single system clock domain with an asynchronous active-low reset.

Top module: `tape_strobe_ctrl`

## Requirements
- R1: A rising edge of `sprocket_i` while `buf_full_i` is low drives `strobe_n_o` low (0 = load active).
- R2: `buf_full_i` high returns `strobe_n_o` to 1. A sprocket rising edge seen while `buf_full_i` is already high produces no strobe.
- R3: With `buf_full_i` high and `sprocket_i` high, the motor coasts: `motor_run_o` = 0 and `brake_o` = 0.
- R4: With `buf_full_i` high and `sprocket_i` low, the brake is applied: `motor_run_o` = 0 and `brake_o` = 1.
- R5: With `buf_full_i` low, the motor runs: `motor_run_o` = 1 and `brake_o` = 0.
- R6: Suppose `strobe_n_o` stays low for `TIMEOUT_CLKS` clocks without `buf_full_i` rising. Then `alarm_o` goes to 1 and stays at 1 until reset. The strobe stays low until the flag rises.
- R7: If the synchronised buffer-full flag arrives in the same clock in which the timeout would expire, the acknowledge wins and `alarm_o` stays 0. An acknowledge one clock later still raises the alarm.
- R8: While reset is asserted, the outputs are `strobe_n_o` = 1, `motor_run_o` = 0, `brake_o` = 1 and `alarm_o` = 0.
- R9: Only a rising edge of the sprocket starts a strobe. If `buf_full_i` clears while the sprocket is still held high, no second strobe follows.
- R10: Each input passes two synchronising flops and one output register. A change driven before clock edge 1 is visible on the outputs after edge 3 and not after edge 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sprocket_i | input | 1 | Sprocket hole present (1 = hole under sensor) |
| buf_full_i | input | 1 | Input port buffer-full flag |
| strobe_n_o | output | 1 | Latch strobe to the port, active low |
| motor_run_o | output | 1 | Reader motor drive |
| brake_o | output | 1 | Reader brake |
| alarm_o | output | 1 | Latched lost-data alarm |

## Verification
The strobe acknowledge and the expiry of the stuck-strobe timeout can fall in the same clock. In that case the design must favour the acknowledge. The bench provokes this case by starting a strobe with the flag low. It then raises `buf_full_i` exactly `TIMEOUT_CLKS` negative edges after the sprocket, which lands the synchronised flag on the expiry edge. It repeats the test one clock later. It judges the alarm output: it must stay clear in the first case and be set in the second. The strobe output must return high in both cases.

// File: rtl/tape_strobe_ctrl.sv
module tape_strobe_ctrl #(
  parameter int TIMEOUT_CLKS = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sprocket_i,
  input  logic buf_full_i,
  output logic strobe_n_o,
  output logic motor_run_o,
  output logic brake_o,
  output logic alarm_o
);
  localparam int CW = $clog2(TIMEOUT_CLKS + 1);

  typedef enum logic [1:0] {M_BRAKE, M_RUN, M_COAST} motor_e;

  logic [1:0] sp_sync, bf_sync;
  logic       sp_q;
  logic       sp_s, bf_s, sp_rise;
  logic [CW-1:0] cnt;
  logic       expire;
  motor_e     motor;

  assign sp_s    = sp_sync[1];
  assign bf_s    = bf_sync[1];
  assign sp_rise = sp_s & ~sp_q;
  assign expire  = ~strobe_n_o & ~bf_s & (cnt == CW'(TIMEOUT_CLKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_sync <= '0;
      bf_sync <= '0;
      sp_q    <= 1'b0;
    end else begin
      sp_sync <= {sp_sync[0], sprocket_i};
      bf_sync <= {bf_sync[0], buf_full_i};
      sp_q    <= sp_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      strobe_n_o <= 1'b1;
    else if (bf_s)                   strobe_n_o <= 1'b1;
    else if (sp_rise && strobe_n_o)  strobe_n_o <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      alarm_o <= 1'b0;
    end else begin
      if (expire) alarm_o <= 1'b1;
      if (strobe_n_o || bf_s)  cnt <= '0;
      else if (!expire)        cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     motor <= M_BRAKE;
    else if (!bf_s) motor <= M_RUN;
    else if (sp_s)  motor <= M_COAST;
    else            motor <= M_BRAKE;
  end

  assign motor_run_o = (motor == M_RUN);
  assign brake_o     = (motor == M_BRAKE);

  AST_ACK_ENDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    bf_s |=> strobe_n_o); // R2
  AST_COAST: assert property (@(posedge clk) disable iff (!rst_n)
    (bf_s && sp_s) |=> (!motor_run_o && !brake_o)); // R3
  AST_BRAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (bf_s && !sp_s) |=> (brake_o && !motor_run_o)); // R4
  AST_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !bf_s |=> (motor_run_o && !brake_o)); // R5
  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_o |=> alarm_o); // R6
  AST_ALARM_ON_STUCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_o) |-> !strobe_n_o); // R6
  AST_ACK_BLOCKS_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    (bf_s && !alarm_o) |=> !alarm_o); // R7
endmodule

// File: tb/sim_tape_strobe_ctrl.sv
`timescale 1ns/1ps
module sim_tape_strobe_ctrl;
  localparam int T = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sprocket = 1'b0;
  logic buf_full = 1'b0;
  logic strobe_n, run, brake, alarm;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tape_strobe_ctrl #(.TIMEOUT_CLKS(T)) u0 (
    .clk(clk), .rst_n(rst_n), .sprocket_i(sprocket), .buf_full_i(buf_full),
    .strobe_n_o(strobe_n), .motor_run_o(run), .brake_o(brake), .alarm_o(alarm)
  );

  // {sprocket, buf_full, strobe_n, run, brake, alarm}
  localparam logic [5:0] VEC [12] = '{
    6'b00_1100, // R5 idle
    6'b10_0100, // R1 strobe
    6'b11_1000, // R2 R3 ack ends strobe, coast
    6'b10_1100, // R9 no second strobe, R5 run
    6'b00_1100,
    6'b10_0100, // R1
    6'b11_1000, // R3
    6'b01_1010, // R4 brake
    6'b00_1100, // R5
    6'b11_1000, // R2 edge with full flag: no strobe
    6'b01_1010, // R4
    6'b00_1100  // R5
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: strobe_n/run/brake/alarm actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sprocket = 1'b0;
    buf_full = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8", {strobe_n, run, brake, alarm}, 4'b1010);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();

    for (int i = 0; i < 12; i++) begin
      sprocket = VEC[i][5];
      buf_full = VEC[i][4];
      repeat (4) @(negedge clk);
      chk($sformatf("R1-5/R9 vector %0d", i), {strobe_n, run, brake, alarm}, VEC[i][3:0]);
    end

    // R10 latency
    do_reset();
    @(negedge clk); sprocket = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R10 after edge 2", {strobe_n, run, brake, alarm}, 4'b1100);
    @(negedge clk);
    chk("R10 after edge 3", {strobe_n, run, brake, alarm}, 4'b0100);

    // R6 stuck strobe
    repeat (T + 4) @(negedge clk);
    chk("R6 alarm set", {strobe_n, run, brake, alarm}, 4'b0101);
    buf_full = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6 alarm held after ack", {strobe_n, run, brake, alarm}, 4'b1001);
    buf_full = 1'b0; sprocket = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 alarm held until reset", {strobe_n, run, brake, alarm}, 4'b1101);

    // R7 ack in the expiry clock wins
    do_reset();
    @(negedge clk); sprocket = 1'b1;
    repeat (T) @(negedge clk); buf_full = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 same-clock ack", {strobe_n, run, brake, alarm}, 4'b1000);

    // R7 ack one clock late
    do_reset();
    @(negedge clk); sprocket = 1'b1;
    repeat (T + 1) @(negedge clk); buf_full = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 late ack", {strobe_n, run, brake, alarm}, 4'b1001);

    do_reset();
    chk("R8 alarm cleared", {strobe_n, run, brake, alarm}, 4'b1100);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule